// File: doc/BRIEF.md
# Accumulator Processor Core with Stack

A small 8-bit processor built around a single accumulator. It fetches 16-bit instruction words from a 32-entry program table that is synthesised as constant logic. Each word has the opcode in bits [15:8] and an immediate, RAM address or branch target in bits [7:0]; addresses use only the low 5 bits. Data lives in a 32-byte RAM. A hardware stack shares that RAM: its pointer starts at the top address and moves downward. The core drives an 8-bit GPIO output latch and reads an 8-bit GPIO input directly. Six peripheral instructions (send a serial byte, read transmitter status, set the baud divisor, set the timer prescaler, read the timer count, clear the timer) run through a one-cycle strobe/data/read port. The serialiser and the counter sit outside the block.

A controller steps through named states. From `S_FETCH` to `S_DECODE`, the instruction word is latched and the PC is incremented. From `S_DECODE`, the core goes to `S_MEMRD` when the instruction needs a RAM operand (add-from-RAM, subtract-from-RAM, pop, return); every other instruction goes straight to `S_EXEC`. From `S_MEMRD` to `S_EXEC`, the RAM byte is registered. From `S_EXEC`, the core returns to `S_FETCH`, or goes to `S_HALT` on the halt instruction. `S_HALT` holds until reset. The zero and carry flags change on arithmetic, logic and shift results. Carry takes the add carry-out, the subtract borrow, or the bit shifted out. Logic operations clear carry.

The built-in program does the following in order:
- counts 1 to 5 on the GPIO,
- calls a subroutine that pushes and pops 6 and shows it,
- sends 0x48 through the peripheral port,
- reads the timer count and shows it,
- shifts 0xC0 left and branches on the carry,
- adds RAM byte 0 (which holds 5) and shows 0x85,
- copies the GPIO input to the output,
- halts.

Top module: `acc_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, the core clears `gpio_out` to 0 and `halted` to 0, and `per_stb` is 0. After release, execution restarts at program address 0.
- R2: Most instructions take three cycles: FETCH, DECODE, EXEC. Add-from-RAM, subtract-from-RAM, pop and return take four, because MEM_READ sits between DECODE and EXEC. The built-in program sets `halted` on the 162nd rising edge after reset is released.
- R3: The loop made of increment, OUT, store, subtract-immediate, branch-if-zero, load-from-RAM and jump shows 1, 2, 3, 4, 5 on `gpio_out`, each value as a separate change.
- R4: A call pushes the return address at the stack pointer and then decrements it. A push does the same with the accumulator. A pop increments the pointer and then reads, and a return does the same. The subroutine shows 6, and execution resumes after the call.
- R5: A peripheral instruction raises `per_stb` for exactly its EXEC cycle. `per_wdata` carries the accumulator. `per_op` codes are 0 send byte, 1 TX status read, 2 baud divisor, 3 prescaler, 4 count read, 5 clear. The program makes exactly two strobes: code 0 with data 0x48, then code 4.
- R6: The status-read and count-read instructions load the accumulator from `per_rdata`. The program then shows that value on `gpio_out`.
- R7: A left shift of 0xC0 sets carry, and the branch-on-carry is taken. Adding RAM byte 0 (value 5) to 0x80 then shows 0x85.
- R8: The input instruction loads the accumulator from `gpio_in`. The program's last output shows that value.
- R9: After the halt instruction, `halted` stays 1, `gpio_out` stays unchanged and `per_stb` stays 0 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| gpio_in | input | 8 | GPIO input pins read by the input instruction |
| gpio_out | output | 8 | Latched GPIO output |
| halted | output | 1 | High once the halt instruction has executed |
| per_stb | output | 1 | One-cycle peripheral command strobe |
| per_op | output | 3 | Peripheral command code |
| per_wdata | output | 8 | Peripheral write data (accumulator) |
| per_rdata | input | 8 | Peripheral read data (TX status or timer count) |

## Verification
The bench tracks every change on `gpio_out` and every strobe over whole program runs, using several `per_rdata`/`gpio_in` pairs.

Each likely fault shows up differently:
- A wrong loop-exit condition or zero-flag update gives too many or too few count values.
- A stack pointer that moves at the wrong moment, or a return that pops the wrong slot, loses the 6 or sends execution to the wrong place.
- A shift that drops the carry reaches the halt that the branch skips, so the run stops early and the sequence is short.
- A missing or extra MEM_READ state moves the halt edge away from 162.

After the halt, the bench confirms that the outputs stay frozen. A reset in the middle of the count must clear the outputs and restart the count from 1.

// File: rtl/acc_pkg.sv
package acc_pkg;

    typedef enum logic [7:0] {
        OP_NOP  = 8'h00, OP_LDA  = 8'h01, OP_ADD  = 8'h02, OP_SUB  = 8'h03,
        OP_AND  = 8'h04, OP_OR   = 8'h05, OP_XOR  = 8'h06, OP_NOT  = 8'h07,
        OP_SHL  = 8'h08, OP_SHR  = 8'h09, OP_INC  = 8'h0A, OP_DEC  = 8'h0B,
        OP_STA  = 8'h10, OP_LDM  = 8'h11, OP_ADDA = 8'h12, OP_SUBA = 8'h13,
        OP_JMP  = 8'h20, OP_JZ   = 8'h21, OP_JNZ  = 8'h22, OP_JC   = 8'h23,
        OP_PUSH = 8'h30, OP_POP  = 8'h31, OP_CALL = 8'h32, OP_RET  = 8'h33,
        OP_IN   = 8'h40, OP_OUT  = 8'h41,
        OP_PSND = 8'h50, OP_PSTS = 8'h51, OP_PBRD = 8'h52,
        OP_PPRS = 8'h53, OP_PCNT = 8'h54, OP_PCLR = 8'h55,
        OP_HLT  = 8'hFF
    } opcode_e;

    typedef enum logic [2:0] {
        S_FETCH, S_DECODE, S_MEMRD, S_EXEC, S_HALT
    } state_e;

endpackage

// File: rtl/acc_prog_rom.sv
module acc_prog_rom
    import acc_pkg::*;
#(
    parameter int PC_W = 5
) (
    input  logic [PC_W-1:0] addr,
    output logic [15:0]     data
);

    always_comb begin
        data = {OP_NOP, 8'h00};
        case (32'(addr))
            0:  data = {OP_LDA,  8'h00};
            1:  data = {OP_INC,  8'h00};
            2:  data = {OP_OUT,  8'h00};
            3:  data = {OP_STA,  8'h00};
            4:  data = {OP_SUB,  8'h05};
            5:  data = {OP_JZ,   8'h08};
            6:  data = {OP_LDM,  8'h00};
            7:  data = {OP_JMP,  8'h01};
            8:  data = {OP_CALL, 8'h18};
            9:  data = {OP_LDA,  8'h48};
            10: data = {OP_PSND, 8'h00};
            11: data = {OP_PCNT, 8'h00};
            12: data = {OP_OUT,  8'h00};
            13: data = {OP_LDA,  8'hC0};
            14: data = {OP_SHL,  8'h00};
            15: data = {OP_JC,   8'h11};
            16: data = {OP_HLT,  8'h00};
            17: data = {OP_ADDA, 8'h00};
            18: data = {OP_OUT,  8'h00};
            19: data = {OP_IN,   8'h00};
            20: data = {OP_OUT,  8'h00};
            21: data = {OP_HLT,  8'h00};
            24: data = {OP_LDA,  8'h06};
            25: data = {OP_PUSH, 8'h00};
            26: data = {OP_LDA,  8'h00};
            27: data = {OP_POP,  8'h00};
            28: data = {OP_OUT,  8'h00};
            29: data = {OP_RET,  8'h00};
            default: data = {OP_NOP, 8'h00};
        endcase
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
(
    input  opcode_e    op,
    input  logic [7:0] a,
    input  logic [7:0] b,
    output logic [7:0] y,
    output logic       c,
    output logic       z,
    output logic       upd
);

    logic [8:0] r;

    always_comb begin
        r   = '0;
        upd = 1'b1;
        unique case (op)
            OP_ADD, OP_ADDA: r = {1'b0, a} + {1'b0, b};
            OP_SUB, OP_SUBA: r = {1'b0, a} - {1'b0, b};
            OP_INC:          r = {1'b0, a} + 9'd1;
            OP_DEC:          r = {1'b0, a} - 9'd1;
            OP_AND:          r = {1'b0, a & b};
            OP_OR:           r = {1'b0, a | b};
            OP_XOR:          r = {1'b0, a ^ b};
            OP_NOT:          r = {1'b0, ~a};
            OP_SHL:          r = {a[7], a[6:0], 1'b0};
            OP_SHR:          r = {a[0], 1'b0, a[7:1]};
            default: begin
                r   = '0;
                upd = 1'b0;
            end
        endcase
        y = r[7:0];
        c = r[8];
        z = (r[7:0] == 8'h00);
    end

endmodule

// File: rtl/acc_dram.sv
module acc_dram #(
    parameter int AW = 5,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_pkg::*;
#(
    parameter int PC_W   = 5,
    parameter int RAM_AW = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] gpio_in,
    output logic [7:0] gpio_out,
    output logic       halted,
    output logic       per_stb,
    output logic [2:0] per_op,
    output logic [7:0] per_wdata,
    input  logic [7:0] per_rdata
);

    localparam int DW = 8;
    localparam int IW = 2 * DW;
    localparam logic [RAM_AW-1:0] SP_TOP = '1;

    state_e            state_q, state_d;
    logic [PC_W-1:0]   pc_q;
    logic [IW-1:0]     ir_q, rom_data;
    logic [DW-1:0]     acc_q, mdr_q, gpio_q;
    logic [RAM_AW-1:0] sp_q;
    logic              zf_q, cf_q, halt_q;

    opcode_e           op;
    logic [DW-1:0]     imm, alu_b, alu_y, ram_rdata, ram_wdata;
    logic              alu_c, alu_z, alu_upd;
    logic              needs_mem, stack_rd, ram_we, is_per, in_exec;
    logic [RAM_AW-1:0] ram_raddr, ram_waddr;

    assign op        = opcode_e'(ir_q[IW-1:DW]);
    assign imm       = ir_q[DW-1:0];
    assign in_exec   = (state_q == S_EXEC);
    assign stack_rd  = (op == OP_POP) || (op == OP_RET);
    assign needs_mem = stack_rd || (op == OP_ADDA) || (op == OP_SUBA);
    assign is_per    = (op == OP_PSND) || (op == OP_PSTS) || (op == OP_PBRD) ||
                       (op == OP_PPRS) || (op == OP_PCNT) || (op == OP_PCLR);
    assign alu_b     = ((op == OP_ADDA) || (op == OP_SUBA)) ? mdr_q : imm;

    assign ram_raddr = stack_rd ? sp_q : imm[RAM_AW-1:0];
    assign ram_we    = in_exec && ((op == OP_STA) || (op == OP_PUSH) || (op == OP_CALL));
    assign ram_waddr = (op == OP_STA) ? imm[RAM_AW-1:0] : sp_q;
    assign ram_wdata = (op == OP_CALL) ? DW'(pc_q) : acc_q;

    acc_prog_rom #(.PC_W(PC_W)) u_rom (.addr(pc_q), .data(rom_data));

    acc_alu u_alu (
        .op(op), .a(acc_q), .b(alu_b),
        .y(alu_y), .c(alu_c), .z(alu_z), .upd(alu_upd)
    );

    acc_dram #(.AW(RAM_AW), .DW(DW)) u_ram (
        .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
        .raddr(ram_raddr), .rdata(ram_rdata)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_FETCH;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_FETCH:  state_d = S_DECODE;
            S_DECODE: state_d = needs_mem ? S_MEMRD : S_EXEC;
            S_MEMRD:  state_d = S_EXEC;
            S_EXEC:   state_d = (op == OP_HLT) ? S_HALT : S_FETCH;
            S_HALT:   state_d = S_HALT;
            default:  state_d = S_FETCH;
        endcase
    end

    // datapath and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= '0;
            ir_q   <= '0;
            acc_q  <= '0;
            mdr_q  <= '0;
            gpio_q <= '0;
            sp_q   <= SP_TOP;
            zf_q   <= 1'b0;
            cf_q   <= 1'b0;
            halt_q <= 1'b0;
        end else begin
            unique case (state_q)
                S_FETCH: begin
                    ir_q <= rom_data;
                    pc_q <= pc_q + 1'b1;
                end
                S_DECODE: if (stack_rd) sp_q <= sp_q + 1'b1;
                S_MEMRD:  mdr_q <= ram_rdata;
                S_EXEC: begin
                    if (alu_upd) begin
                        acc_q <= alu_y;
                        zf_q  <= alu_z;
                        cf_q  <= alu_c;
                    end
                    case (op)
                        OP_LDA:           acc_q  <= imm;
                        OP_LDM:           acc_q  <= ram_rdata;
                        OP_JMP:           pc_q   <= imm[PC_W-1:0];
                        OP_JZ:   if (zf_q)  pc_q <= imm[PC_W-1:0];
                        OP_JNZ:  if (!zf_q) pc_q <= imm[PC_W-1:0];
                        OP_JC:   if (cf_q)  pc_q <= imm[PC_W-1:0];
                        OP_PUSH:          sp_q   <= sp_q - 1'b1;
                        OP_CALL: begin
                            sp_q <= sp_q - 1'b1;
                            pc_q <= imm[PC_W-1:0];
                        end
                        OP_POP:           acc_q  <= mdr_q;
                        OP_RET:           pc_q   <= mdr_q[PC_W-1:0];
                        OP_IN:            acc_q  <= gpio_in;
                        OP_OUT:           gpio_q <= acc_q;
                        OP_PSTS, OP_PCNT: acc_q  <= per_rdata;
                        OP_HLT:           halt_q <= 1'b1;
                        default: ;
                    endcase
                end
                S_HALT: ;
                default: ;
            endcase
        end
    end

    assign gpio_out  = gpio_q;
    assign halted    = halt_q;
    assign per_stb   = in_exec && is_per;
    assign per_op    = op[2:0];
    assign per_wdata = acc_q;

    // ---------------- assertions ----------------
    assert_memrd_to_exec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_MEMRD) |=> (state_q == S_EXEC));

    assert_decode_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DECODE) |=> (state_q == S_MEMRD || state_q == S_EXEC));

    assert_gpio_only_exec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_EXEC) |=> $stable(gpio_out));

    assert_push_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_exec && (op == OP_PUSH || op == OP_CALL))
        |=> (sp_q == RAM_AW'($past(sp_q) - 1'b1)));

    assert_pop_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DECODE && stack_rd)
        |=> (sp_q == RAM_AW'($past(sp_q) + 1'b1)));

    assert_stb_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        per_stb |=> !per_stb);

    assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(gpio_out)));

    assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!per_stb && !ram_we));

endmodule

// File: tb/acc_core_tb.sv
`timescale 1ns/1ps
module acc_core_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] gpio_in = 8'h00;
    logic [7:0] per_rdata = 8'h00;
    logic [7:0] gpio_out, per_wdata;
    logic [2:0] per_op;
    logic       halted, per_stb;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    acc_core u_dut (
        .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in), .gpio_out(gpio_out),
        .halted(halted), .per_stb(per_stb), .per_op(per_op),
        .per_wdata(per_wdata), .per_rdata(per_rdata)
    );

    // stimulus per run: {per_rdata, gpio_in}
    localparam int NRUN = 3;
    localparam logic [15:0] RUN_VEC [NRUN] = '{16'h372A, 16'h5A99, 16'hE110};
    localparam int HALT_EDGE = 162;

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold_reset();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        check(gpio_out == 8'h00, "R1 gpio_out in reset", 32'(gpio_out), 0);
        check(halted == 1'b0,    "R1 halted in reset",   32'(halted), 0);
        check(per_stb == 1'b0,   "R1 per_stb in reset",  32'(per_stb), 0);
        rst_n = 1'b1;
    endtask

    task automatic run_program(input logic [7:0] rd, input logic [7:0] gin);
        logic [7:0] exp_seq [9];
        logic [7:0] seen [16];
        logic [2:0] stb_op [4];
        logic [7:0] stb_dat [4];
        logic [7:0] last;
        int nseen = 0;
        int nstb = 0;
        int cyc = 0;
        exp_seq = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, rd, 8'h85, gin};
        per_rdata = rd;
        gpio_in   = gin;
        last = gpio_out;
        while (cyc < 1000) begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
            if (gpio_out != last) begin
                if (nseen < 16) seen[nseen] = gpio_out;
                nseen++;
                last = gpio_out;
            end
            if (per_stb) begin
                if (nstb < 4) begin
                    stb_op[nstb]  = per_op;
                    stb_dat[nstb] = per_wdata;
                end
                nstb++;
            end
            if (halted) break;
        end
        check(halted == 1'b1, "R9 run reached halt (watchdog)", 32'(halted), 1);
        check(cyc == HALT_EDGE, "R2 halt edge count", 32'(cyc), HALT_EDGE);
        check(nseen == 9, "R3 number of gpio changes", 32'(nseen), 9);
        for (int i = 0; i < 9; i++) begin
            if (i < nseen) begin
                if (i < 5)
                    check(seen[i] == exp_seq[i], "R3 count value", 32'(seen[i]), 32'(exp_seq[i]));
                else if (i == 5)
                    check(seen[i] == exp_seq[i], "R4 subroutine value", 32'(seen[i]), 32'(exp_seq[i]));
                else if (i == 6)
                    check(seen[i] == exp_seq[i], "R6 count read value", 32'(seen[i]), 32'(exp_seq[i]));
                else if (i == 7)
                    check(seen[i] == exp_seq[i], "R7 shift carry and add value", 32'(seen[i]), 32'(exp_seq[i]));
                else
                    check(seen[i] == exp_seq[i], "R8 gpio input value", 32'(seen[i]), 32'(exp_seq[i]));
            end
        end
        check(nstb == 2, "R5 strobe count", 32'(nstb), 2);
        if (nstb >= 2) begin
            check(stb_op[0] == 3'd0,   "R5 first strobe code", 32'(stb_op[0]), 0);
            check(stb_dat[0] == 8'h48, "R5 first strobe data", 32'(stb_dat[0]), 32'h48);
            check(stb_op[1] == 3'd4,   "R5 second strobe code", 32'(stb_op[1]), 4);
        end
        // after halt: frozen
        last = gpio_out;
        nstb = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (per_stb) nstb++;
            if (!halted || gpio_out != last) nstb += 100;
        end
        check(nstb == 0, "R9 frozen after halt", 32'(nstb), 0);
        check(gpio_out == gin, "R9 gpio held after halt", 32'(gpio_out), 32'(gin));
    endtask

    initial begin
        #500us;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // vector table walk
        for (int r = 0; r < NRUN; r++) begin
            hold_reset();
            run_program(RUN_VEC[r][15:8], RUN_VEC[r][7:0]);
        end

        // reset in the middle of the count: R1
        hold_reset();
        gpio_in = 8'h2A;
        per_rdata = 8'h37;
        repeat (40) @(negedge clk);
        check(gpio_out != 8'h00, "R1 program running before reset", 32'(gpio_out), 1);
        rst_n = 1'b0;
        @(negedge clk);
        check(gpio_out == 8'h00, "R1 gpio cleared by midrun reset", 32'(gpio_out), 0);
        check(halted == 1'b0, "R1 halted cleared by midrun reset", 32'(halted), 0);
        rst_n = 1'b1;
        // first OUT is instruction 2: edges 1..9, gpio becomes 1 at edge 9
        repeat (8) @(negedge clk);
        check(gpio_out == 8'h00, "R1 restart, before first OUT", 32'(gpio_out), 0);
        @(negedge clk);
        check(gpio_out == 8'h01, "R1 restart, first OUT value", 32'(gpio_out), 1);

        // reset after a halt releases it: R1 and R9
        hold_reset();
        run_program(8'h37, 8'h2A);
        rst_n = 1'b0;
        @(negedge clk);
        check(halted == 1'b0, "R9 halt released only by reset", 32'(halted), 0);
        rst_n = 1'b1;

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule